// File: doc/BRIEF.md
# Multi-Channel Event Timer

The block keeps a 64-bit up-counter that advances by one on every clock while a global run bit is set. Several comparator channels watch that counter. A channel fires only when the counter equals its compare value exactly. It can then pulse or hold an interrupt line chosen by its route field, emit a message that carries a data word and an address word, or, when the global legacy bit is set, drive one of two fixed legacy lines. Software reaches everything through a word-addressed 32-bit register port with a combinational read.

Each channel is a small state machine with three states. CH_OFF means the channel is disarmed. CH_ONESHOT means it fires once per equal match. CH_PERIODIC means it adds a stored period to its compare value on every match. A config write moves the channel between states. The ARM transition goes from CH_OFF to CH_ONESHOT or CH_PERIODIC when the enable bit is written as 1. The RETUNE transition goes between CH_ONESHOT and CH_PERIODIC when the periodic bit changes with enable still 1. The DISARM transition returns to CH_OFF when enable is written as 0. Channel 1 cannot enter CH_PERIODIC.

Register map (word addresses): 0x00 identity, 0x01 tick period in femtoseconds, 0x02 global config (bit 0 run, bit 1 legacy), 0x03 level status, 0x04/0x05 counter low/high. Channel n starts at 0x08+8n and holds the following words: +0 config, +1/+2 compare low/high, +3 message data, +4 message address. Channel config bits: 0 level, 1 enable, 2 periodic, 3 periodic-capable (read only), 4 wide-capable (read only, 1), 5 set-value, 6 narrow 32-bit mode, 11:7 route, 12 message enable, 13 message-capable (read only, 1).

Top module: `evt_timer_top`

## Requirements
- R1: After reset, the counter reads 0. The identity word holds NUM_CH-1 in bits 4:0 and the legacy-capable flag in bit 8. The period word reads PERIOD_FS.
- R2: While global config bit 0 is 1, the counter rises by exactly 1 per clock. While that bit is 0, the counter holds its value.
- R3: Writes to the counter halves (0x04, 0x05) load the counter only while bit 0 of the global config is 0. While the counter runs, such writes have no effect.
- R4: An enabled channel fires only when the counter equals its compare value. In edge mode (config bit 0 = 0), a one-clock pulse appears on irq_line[route] in the clock after the equal count. A compare value that the counter has already passed does not fire.
- R5: With config bit 6 set, only the low 32 bits of the counter and the compare value take part in the match, so a channel fires again after the low word wraps. With bit 6 clear, all 64 bits must match.
- R6: In the periodic state, a compare-low write made while set-value (bit 5) is 1 loads the compare value and clears bit 5. Later compare writes load the period, and each match adds the period to the compare value.
- R7: On channel 1, config bits 2 and 3 always read 0. A write with the periodic bit set arms a one-shot channel, and every compare write then loads the compare value.
- R8: In level mode (config bit 0 = 1), a match sets status bit n at 0x03. The routed line stays high while that bit is set. Writing 1 to the bit clears it.
- R9: With global config bit 1 set, channel 0 drives legacy_timer_irq and channel 1 drives legacy_rtc_irq, whatever their route fields hold. Neither channel then reaches irq_line.
- R10: A channel with config bit 12 set emits a one-clock msg_valid on a match, with msg_data from its word +3 and msg_addr from its word +4. It drives no line. If several channels match at once, the lowest index wins.
- R11: Channel config reads back the stored fields, together with the read-only capability bits 3, 4 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_line | output | NUM_LINES | Routed interrupt lines |
| legacy_timer_irq | output | 1 | Legacy system-timer line (channel 0) |
| legacy_rtc_irq | output | 1 | Legacy RTC line (channel 1) |
| msg_valid | output | 1 | Message emission strobe |
| msg_data | output | 32 | Message data word |
| msg_addr | output | 32 | Message address word |

## Verification
The bench builds the block with its defaults: four channels, eight lines and a 64-bit counter. With four channels, the legacy pair (channels 0 and 1) and the routed and message channels (2 and 3) can all be tested in one build, and channel 1 exercises the missing periodic capability. Because the counter halves can be preloaded, the bench starts the counter just below a 32-bit wrap and reaches the narrow-mode re-match within a few tens of clocks. Table rows contrast 32-bit and 64-bit matching across that wrap, and also cover a compare value behind the counter and one equal to the start value.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    // global register word addresses
    localparam logic [7:0] A_ID      = 8'h00;
    localparam logic [7:0] A_PERIOD  = 8'h01;
    localparam logic [7:0] A_GCFG    = 8'h02;
    localparam logic [7:0] A_STATUS  = 8'h03;
    localparam logic [7:0] A_CNT_LO  = 8'h04;
    localparam logic [7:0] A_CNT_HI  = 8'h05;
    localparam logic [7:0] A_CH_BASE = 8'h08;
    localparam int         CH_STRIDE_LG = 3;

    // per-channel word offsets
    localparam logic [2:0] O_CFG     = 3'd0;
    localparam logic [2:0] O_CMP_LO  = 3'd1;
    localparam logic [2:0] O_CMP_HI  = 3'd2;
    localparam logic [2:0] O_RT_DATA = 3'd3;
    localparam logic [2:0] O_RT_ADDR = 3'd4;

    // channel config bit positions
    localparam int B_LEVEL  = 0;
    localparam int B_EN     = 1;
    localparam int B_PER    = 2;
    localparam int B_PERCAP = 3;
    localparam int B_WIDE   = 4;
    localparam int B_SETVAL = 5;
    localparam int B_F32    = 6;
    localparam int B_ROUTE  = 7;
    localparam int ROUTE_W  = 5;
    localparam int B_MSG    = 12;
    localparam int B_MSGCAP = 13;

    // global config bits
    localparam int G_RUN = 0;
    localparam int G_LEG = 1;

    typedef enum logic [1:0] {
        CH_OFF      = 2'd0,
        CH_ONESHOT  = 2'd1,
        CH_PERIODIC = 2'd2
    } ch_state_e;
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   count
);
    localparam int HALF = CNT_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (run) begin
            count <= count + CNT_W'(1);
        end else begin
            if (wr_lo) count[HALF-1:0]     <= wdata;
            if (wr_hi) count[CNT_W-1:HALF] <= wdata;
        end
    end

    // R2: a running counter steps by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> count == $past(count) + CNT_W'(1));

    // R2: a stopped counter with no load keeps its value
    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_timer_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter bit PER_CAP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [CNT_W-1:0]   count,
    input  logic               wr_cfg,
    input  logic               wr_cmp_lo,
    input  logic               wr_cmp_hi,
    input  logic               wr_rt_data,
    input  logic               wr_rt_addr,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [31:0]        cfg_word,
    output logic [CNT_W-1:0]   cmp_word,
    output logic [31:0]        rt_data,
    output logic [31:0]        rt_addr,
    output logic               hit,
    output logic               level,
    output logic [ROUTE_W-1:0] route,
    output logic               msg_en
);
    localparam int HALF = CNT_W / 2;

    ch_state_e          state_q, nxt_state;
    logic [CNT_W-1:0]   cmp_q, per_q, cmp_sum;
    logic               level_q, setval_q, f32_q, msg_q, hit_q;
    logic [ROUTE_W-1:0] route_q;
    logic               want_en, want_per, cmp_eq, match, reload, to_period;

    assign want_en   = wdata[B_EN];
    assign want_per  = wdata[B_PER] & PER_CAP;
    assign to_period = (state_q == CH_PERIODIC) && !setval_q;
    assign cmp_eq    = f32_q ? (count[HALF-1:0] == cmp_q[HALF-1:0]) : (count == cmp_q);
    assign cmp_sum   = f32_q ? {{HALF{1'b0}}, cmp_q[HALF-1:0] + per_q[HALF-1:0]}
                             : cmp_q + per_q;

    // next-state: ARM, RETUNE, DISARM
    always_comb begin
        nxt_state = state_q;
        unique case (state_q)
            CH_OFF:
                if (wr_cfg && want_en)
                    nxt_state = want_per ? CH_PERIODIC : CH_ONESHOT;
            CH_ONESHOT, CH_PERIODIC:
                if (wr_cfg)
                    nxt_state = !want_en ? CH_OFF : (want_per ? CH_PERIODIC : CH_ONESHOT);
            default:
                nxt_state = CH_OFF;
        endcase
    end

    // state outputs: match detection and periodic reload
    always_comb begin
        match  = 1'b0;
        reload = 1'b0;
        unique case (state_q)
            CH_OFF: ;
            CH_ONESHOT:
                match = run && cmp_eq;
            CH_PERIODIC: begin
                match  = run && cmp_eq;
                reload = match;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CH_OFF;
            cmp_q    <= '0;
            per_q    <= '0;
            level_q  <= 1'b0;
            setval_q <= 1'b0;
            f32_q    <= 1'b0;
            msg_q    <= 1'b0;
            route_q  <= '0;
            rt_data  <= '0;
            rt_addr  <= '0;
            hit_q    <= 1'b0;
        end else begin
            state_q <= nxt_state;
            hit_q   <= match;
            if (wr_cfg) begin
                level_q  <= wdata[B_LEVEL];
                setval_q <= wdata[B_SETVAL];
                f32_q    <= wdata[B_F32];
                msg_q    <= wdata[B_MSG];
                route_q  <= wdata[B_ROUTE +: ROUTE_W];
            end
            if (wr_cmp_lo) begin
                if (to_period) per_q[HALF-1:0] <= wdata;
                else           cmp_q[HALF-1:0] <= wdata;
                setval_q <= 1'b0;
            end else if (wr_cmp_hi) begin
                if (to_period) per_q[CNT_W-1:HALF] <= wdata;
                else           cmp_q[CNT_W-1:HALF] <= wdata;
            end else if (reload) begin
                cmp_q <= cmp_sum;
            end
            if (wr_rt_data) rt_data <= wdata;
            if (wr_rt_addr) rt_addr <= wdata;
        end
    end

    always_comb begin
        cfg_word                           = '0;
        cfg_word[B_LEVEL]                  = level_q;
        cfg_word[B_EN]                     = (state_q != CH_OFF);
        cfg_word[B_PER]                    = (state_q == CH_PERIODIC);
        cfg_word[B_PERCAP]                 = PER_CAP;
        cfg_word[B_WIDE]                   = 1'b1;
        cfg_word[B_SETVAL]                 = setval_q;
        cfg_word[B_F32]                    = f32_q;
        cfg_word[B_ROUTE +: ROUTE_W]       = route_q;
        cfg_word[B_MSG]                    = msg_q;
        cfg_word[B_MSGCAP]                 = 1'b1;
    end

    assign cmp_word = cmp_q;
    assign hit      = hit_q;
    assign level    = level_q;
    assign route    = route_q;
    assign msg_en   = msg_q;

    // R6: set-value clears after a compare-low write
    p_setval_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmp_lo |=> !setval_q);

    // R4: a disarmed channel raises no match
    p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |=> !hit_q);

    generate
        if (!PER_CAP) begin : g_noper
            // R7: channel without periodic capability never reloads
            p_no_periodic_r7: assert property (@(posedge clk) disable iff (!rst_n)
                state_q != CH_PERIODIC);
        end
    endgenerate
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int          NUM_CH     = 4,
    parameter int          NUM_LINES  = 8,
    parameter int          CNT_W      = 64,
    parameter logic [31:0] PERIOD_FS  = 32'd10_000_000,
    parameter bit          LEGACY_CAP = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_LINES-1:0] irq_line,
    output logic                 legacy_timer_irq,
    output logic                 legacy_rtc_irq,
    output logic                 msg_valid,
    output logic [31:0]          msg_data,
    output logic [31:0]          msg_addr
);
    localparam int HALF     = CNT_W / 2;
    localparam int BLK_W    = 8 - CH_STRIDE_LG;
    localparam int CH_SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic                run_q, leg_q;
    logic [NUM_CH-1:0]   status_q, st_clr;
    logic [CNT_W-1:0]    count;
    logic [BLK_W-1:0]    ch_idx;
    logic [2:0]          ch_off;
    logic                in_ch;
    logic [CH_SEL_W-1:0] ch_sel;

    logic [31:0]         ch_cfg [NUM_CH];
    logic [CNT_W-1:0]    ch_cmp [NUM_CH];
    logic [31:0]         ch_rtd [NUM_CH];
    logic [31:0]         ch_rta [NUM_CH];
    logic [ROUTE_W-1:0]  ch_route [NUM_CH];
    logic [NUM_CH-1:0]   ch_hit, ch_level, ch_msg, ch_assert;

    assign ch_off = reg_addr[2:0];
    assign ch_idx = reg_addr[7:CH_STRIDE_LG] - BLK_W'(1);
    assign in_ch  = (reg_addr >= A_CH_BASE) && (int'(ch_idx) < NUM_CH);
    assign ch_sel = ch_idx[CH_SEL_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            leg_q <= 1'b0;
        end else if (reg_wr && reg_addr == A_GCFG) begin
            run_q <= reg_wdata[G_RUN];
            leg_q <= reg_wdata[G_LEG] & LEGACY_CAP;
        end
    end

    assign st_clr = (reg_wr && reg_addr == A_STATUS) ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~st_clr) | (ch_hit & ch_level);
    end

    evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .wr_lo (reg_wr && reg_addr == A_CNT_LO && !run_q),
        .wr_hi (reg_wr && reg_addr == A_CNT_HI && !run_q),
        .wdata (reg_wdata[HALF-1:0]),
        .count (count)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            localparam logic [BLK_W-1:0] IDX = BLK_W'(i);
            logic sel;
            assign sel = reg_wr && in_ch && (ch_idx == IDX);
            evt_channel #(.CNT_W(CNT_W), .PER_CAP(i != 1)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .run        (run_q),
                .count      (count),
                .wr_cfg     (sel && ch_off == O_CFG),
                .wr_cmp_lo  (sel && ch_off == O_CMP_LO),
                .wr_cmp_hi  (sel && ch_off == O_CMP_HI),
                .wr_rt_data (sel && ch_off == O_RT_DATA),
                .wr_rt_addr (sel && ch_off == O_RT_ADDR),
                .wdata      (reg_wdata[HALF-1:0]),
                .cfg_word   (ch_cfg[i]),
                .cmp_word   (ch_cmp[i]),
                .rt_data    (ch_rtd[i]),
                .rt_addr    (ch_rta[i]),
                .hit        (ch_hit[i]),
                .level      (ch_level[i]),
                .route      (ch_route[i]),
                .msg_en     (ch_msg[i])
            );

            // R8: a cleared level bit stays clear without a new match
            p_status_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (st_clr[i] && !ch_hit[i]) |=> !status_q[i]);
            // R8: a set level bit persists until written with 1
            p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (status_q[i] && !st_clr[i]) |=> status_q[i]);
        end
    endgenerate

    assign ch_assert = (ch_level & status_q) | (~ch_level & ch_hit);

    always_comb begin
        irq_line         = '0;
        legacy_timer_irq = 1'b0;
        legacy_rtc_irq   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!ch_msg[i]) begin
                if (leg_q && i == 0)      legacy_timer_irq = legacy_timer_irq | ch_assert[i];
                else if (leg_q && i == 1) legacy_rtc_irq   = legacy_rtc_irq | ch_assert[i];
                else begin
                    for (int l = 0; l < NUM_LINES; l++)
                        if (int'(ch_route[i]) == l) irq_line[l] = irq_line[l] | ch_assert[i];
                end
            end
        end
    end

    always_comb begin
        msg_valid = 1'b0;
        msg_data  = '0;
        msg_addr  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (ch_hit[i] && ch_msg[i]) begin
                msg_valid = 1'b1;
                msg_data  = ch_rtd[i];
                msg_addr  = ch_rta[i];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (in_ch) begin
            case (ch_off)
                O_CFG:     reg_rdata = ch_cfg[ch_sel];
                O_CMP_LO:  reg_rdata = ch_cmp[ch_sel][HALF-1:0];
                O_CMP_HI:  reg_rdata = ch_cmp[ch_sel][CNT_W-1:HALF];
                O_RT_DATA: reg_rdata = ch_rtd[ch_sel];
                O_RT_ADDR: reg_rdata = ch_rta[ch_sel];
                default:   reg_rdata = '0;
            endcase
        end else begin
            case (reg_addr)
                A_ID:     reg_rdata = {23'b0, LEGACY_CAP, 3'b0, 5'(NUM_CH - 1)};
                A_PERIOD: reg_rdata = PERIOD_FS;
                A_GCFG:   reg_rdata = {30'b0, leg_q, run_q};
                A_STATUS: reg_rdata = 32'(status_q);
                A_CNT_LO: reg_rdata = count[HALF-1:0];
                A_CNT_HI: reg_rdata = count[CNT_W-1:HALF];
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R9: in legacy mode an edge match on channel 0 reaches the timer line
    p_legacy_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_q && ch_hit[0] && !ch_level[0] && !ch_msg[0]) |-> legacy_timer_irq);

    // R10: a message strobe always comes with a message-enabled match
    p_msg_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (ch_hit & ch_msg) != '0);
endmodule

// File: tb/evt_timer_top_tb_top.sv
module evt_timer_top_tb_top;
    import evt_timer_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam int          NUM_CH     = 4;
    localparam int          NUM_LINES  = 8;
    localparam logic [31:0] PERIOD_FS  = 32'd10_000_000;

    logic                 clk, rst_n, reg_wr;
    logic [7:0]           reg_addr;
    logic [31:0]          reg_wdata, reg_rdata;
    logic [NUM_LINES-1:0] irq_line;
    logic                 legacy_timer_irq, legacy_rtc_irq, msg_valid;
    logic [31:0]          msg_data, msg_addr;

    int checks = 0;
    int failures = 0;

    evt_timer_top #(.NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .PERIOD_FS(PERIOD_FS)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line),
        .legacy_timer_irq(legacy_timer_irq), .legacy_rtc_irq(legacy_rtc_irq),
        .msg_valid(msg_valid), .msg_data(msg_data), .msg_addr(msg_addr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // one-shot table: start count, compare low, narrow mode, pulses, counter low at pulse
    typedef struct packed {
        logic [31:0] start;
        logic [31:0] cmp;
        logic        m32;
        logic [7:0]  hits;
        logic [31:0] lo_at;
    } vec_t;
    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{32'd0,          32'd10, 1'b0, 8'd1, 32'd11},
        '{32'd20,         32'd5,  1'b0, 8'd0, 32'd0},
        '{32'hFFFF_FFF0,  32'd4,  1'b1, 8'd1, 32'd5},
        '{32'hFFFF_FFF0,  32'd4,  1'b0, 8'd0, 32'd0},
        '{32'd5,          32'd5,  1'b0, 8'd1, 32'd6}
    };

    int          line_p, lt_p, lr_p, msg_p;
    logic [31:0] first_lo, last_lo, cur_lo, got_d, got_a;

    function automatic logic [7:0] cha(input int ch, input logic [2:0] off);
        return 8'(8 + ch * 8) | {5'b0, off};
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic preload(input logic [31:0] lo);
        wr(A_GCFG, 32'd0);
        wr(A_CNT_LO, lo);
        wr(A_CNT_HI, 32'd0);
    endtask

    // samples monitored outputs at negedges while the counter runs
    task automatic window(input int n);
        line_p = 0; lt_p = 0; lr_p = 0; msg_p = 0;
        first_lo = '0; last_lo = '0; got_d = '0; got_a = '0;
        reg_addr = A_CNT_LO;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cur_lo = reg_rdata;
            if (irq_line[3]) begin
                if (line_p == 0) first_lo = cur_lo;
                last_lo = cur_lo;
                line_p++;
            end
            if (legacy_timer_irq) lt_p++;
            if (legacy_rtc_irq) lr_p++;
            if (msg_valid) begin msg_p++; got_d = msg_data; got_a = msg_addr; end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset state
        rd(A_CNT_LO, v);  check_eq("R1", "counter after reset", v, 0);
        rd(A_ID, v);      check_eq("R1", "identity word", v, 32'h103);
        rd(A_PERIOD, v);  check_eq("R1", "period word", v, PERIOD_FS);
        rd(cha(0, O_CFG), v); check_eq("R11", "ch0 reset config", v, 32'h2018);
        rd(cha(1, O_CFG), v); check_eq("R11", "ch1 reset config", v, 32'h2010);

        // R4 / R5: one-shot table on channel 2, routed to line 3
        for (int t = 0; t < NVEC; t++) begin
            preload(VECS[t].start);
            wr(cha(2, O_CMP_HI), 32'd0);
            wr(cha(2, O_CMP_LO), VECS[t].cmp);
            wr(cha(2, O_CFG), 32'h182 | (32'(VECS[t].m32) << B_F32));
            wr(A_GCFG, 32'd1);
            window(30);
            wr(A_GCFG, 32'd0);
            wr(cha(2, O_CFG), 32'd0);
            check_eq(VECS[t].m32 ? "R5" : "R4", $sformatf("row %0d pulse count", t),
                     64'(line_p), 64'(VECS[t].hits));
            if (VECS[t].hits != 0)
                check_eq(VECS[t].m32 ? "R5" : "R4", $sformatf("row %0d counter at pulse", t),
                         first_lo, VECS[t].lo_at);
        end

        // R2: counting and freezing
        preload(32'd0);
        wr(A_GCFG, 32'd1);
        window(10);
        check_eq("R2", "counter after 10 clocks", cur_lo, 32'd10);
        wr(A_GCFG, 32'd0);
        rd(A_CNT_LO, v);
        repeat (5) @(negedge clk);
        rd(A_CNT_LO, v2);
        check_eq("R2", "stopped counter holds", v2, v);

        // R3: counter writes only while stopped
        preload(32'd0);
        wr(A_GCFG, 32'd1);
        wr(A_CNT_LO, 32'h1234_5678);
        rd(A_CNT_LO, v);
        check_eq("R3", "running write ignored", 64'(v < 32'd100), 64'd1);
        wr(A_GCFG, 32'd0);
        wr(A_CNT_HI, 32'hA5);
        rd(A_CNT_HI, v);
        check_eq("R3", "stopped write loads", v, 32'hA5);

        // R6: periodic two-write sequence on channel 0
        preload(32'd0);
        wr(cha(0, O_CFG), 32'h1A6);
        wr(cha(0, O_CMP_HI), 32'd0);
        wr(cha(0, O_CMP_LO), 32'd10);
        rd(cha(0, O_CFG), v);
        check_eq("R6", "set-value self-cleared", v, 32'h219E);
        wr(cha(0, O_CMP_LO), 32'd8);
        rd(cha(0, O_CMP_LO), v);
        check_eq("R6", "second write leaves compare", v, 32'd10);
        wr(A_GCFG, 32'd1);
        window(40);
        wr(A_GCFG, 32'd0);
        wr(cha(0, O_CFG), 32'd0);
        check_eq("R6", "periodic pulse count", 64'(line_p), 64'd4);
        check_eq("R6", "first periodic pulse", first_lo, 32'd11);
        check_eq("R6", "last periodic pulse", last_lo, 32'd35);

        // R7: channel 1 refuses periodic mode
        preload(32'd0);
        wr(cha(1, O_CFG), 32'h1A6);
        rd(cha(1, O_CFG), v);
        check_eq("R7", "ch1 config readback", v, 32'h21B2);
        wr(cha(1, O_CMP_HI), 32'd0);
        wr(cha(1, O_CMP_LO), 32'd10);
        wr(cha(1, O_CMP_LO), 32'd8);
        wr(A_GCFG, 32'd1);
        window(40);
        wr(A_GCFG, 32'd0);
        wr(cha(1, O_CFG), 32'd0);
        check_eq("R7", "ch1 single pulse", 64'(line_p), 64'd1);
        check_eq("R7", "ch1 pulse at second compare write", first_lo, 32'd9);

        // R8: level mode with write-one-to-clear status
        preload(32'd0);
        wr(cha(2, O_CMP_HI), 32'd0);
        wr(cha(2, O_CMP_LO), 32'd4);
        wr(cha(2, O_CFG), 32'h183);
        wr(A_GCFG, 32'd1);
        window(10);
        wr(A_GCFG, 32'd0);
        rd(A_STATUS, v);
        check_eq("R8", "status bit set", v, 32'h4);
        check_eq("R8", "line held high", 64'(irq_line[3]), 64'd1);
        wr(A_STATUS, 32'h4);
        rd(A_STATUS, v);
        check_eq("R8", "status cleared", v, 32'h0);
        check_eq("R8", "line released", 64'(irq_line[3]), 64'd0);
        wr(cha(2, O_CFG), 32'd0);

        // R9: legacy routing overrides route fields
        preload(32'd0);
        wr(cha(0, O_CMP_HI), 32'd0);
        wr(cha(0, O_CMP_LO), 32'd5);
        wr(cha(0, O_CFG), 32'h182);
        wr(cha(1, O_CMP_HI), 32'd0);
        wr(cha(1, O_CMP_LO), 32'd7);
        wr(cha(1, O_CFG), 32'h182);
        wr(A_GCFG, 32'd3);
        window(20);
        wr(A_GCFG, 32'd0);
        wr(cha(0, O_CFG), 32'd0);
        wr(cha(1, O_CFG), 32'd0);
        check_eq("R9", "legacy timer pulses", 64'(lt_p), 64'd1);
        check_eq("R9", "legacy rtc pulses", 64'(lr_p), 64'd1);
        check_eq("R9", "routed line silent", 64'(line_p), 64'd0);

        // R10: message delivery on channel 3
        preload(32'd0);
        wr(cha(3, O_RT_DATA), 32'hCAFE_0001);
        wr(cha(3, O_RT_ADDR), 32'hFEE0_0ABC);
        wr(cha(3, O_CMP_HI), 32'd0);
        wr(cha(3, O_CMP_LO), 32'd6);
        wr(cha(3, O_CFG), 32'h1182);
        wr(A_GCFG, 32'd1);
        window(20);
        wr(A_GCFG, 32'd0);
        wr(cha(3, O_CFG), 32'd0);
        check_eq("R10", "message count", 64'(msg_p), 64'd1);
        check_eq("R10", "message data", got_d, 32'hCAFE_0001);
        check_eq("R10", "message address", got_a, 32'hFEE0_0ABC);
        check_eq("R10", "no line from message channel", 64'(line_p), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule